// File: doc/BRIEF.md
# Adaptive FSK Data Slicer

This block turns a stream of signed instantaneous-frequency samples, each measured relative to the intermediate frequency, into hard bit decisions. When the transmitter and receiver disagree in frequency, both tones shift the same way, and a slicer fixed at zero then favours one symbol. This slicer tracks the lowest and highest frequency seen since the last restart. On every large frequency step it forms the midpoint of that range. It then moves its decision level to an average of those midpoints, so the offset drops out.

Small steps, such as noise or a slow drift, are kept out of the estimate. A step counts only when the frequency moves away from the level of the previous counted step by more than a programmable expected deviation. A 2-bit settling code selects how many counted steps are needed before the learned level is used, and how many midpoints are averaged into it. The code 00 turns the adaptation off. The learned level is also output as an estimate of the receiver's frequency offset, for use by an external correction loop.

Top module: `fsk_adaptive_slicer`

## Requirements
- R1: One cycle after a sample is accepted (`valid_i` high, `restart_i` low), `bit_o` is 1 if the sample is strictly greater than the threshold that was in force before that sample, and 0 otherwise. In all other cycles, `bit_o` holds its value.
- R2: The expected deviation, in sample LSBs, is `dev_mant_i << (dev_exp_i + 2)`. With mantissa 5 and exponent 1 it is 40. With mantissa 1 and exponent 3 it is 32.
- R3: The first accepted sample after a restart sets the reference level and is not a step. A later sample is a counted step only if its distance from the reference is strictly greater than the expected deviation. Such a sample becomes the new reference. A distance exactly equal to the deviation is not counted.
- R4: Each counted step yields a midpoint estimate, floor((lo + hi) / 2). Here lo and hi are the minimum and maximum of all samples accepted since the restart, including the current one.
- R5: With settling code 01, every counted step writes its estimate into the learned level. The threshold becomes valid on the 3rd counted step.
- R6: With settling code 10, the estimates are summed in blocks of 8 steps. At the end of each block, the learned level becomes floor(sum / 8). The threshold becomes valid on the 8th counted step.
- R7: With settling code 11, the same rule applies with blocks of 16. The threshold becomes valid on the 16th counted step.
- R8: With settling code 00, `thr_o` is 0, `thr_valid_o` is 0 and decisions are made against 0. The learned level is not updated.
- R9: While `thr_valid_o` is 0, `thr_o` is 0 and decisions are made against 0. While it is 1, `thr_o` equals the learned level.
- R10: `freq_off_o` always shows the learned level, even before the threshold is valid. It changes only at the end of a block.
- R11: A `restart_i` pulse clears the tracked range, the reference, the step count, the block sum, the learned level and the valid flag. A sample presented in the same cycle as `restart_i` is ignored, and `bit_o` holds its value.
- R12: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| restart_i | input | 1 | Clears all learned state; a sample in the same cycle is dropped |
| valid_i | input | 1 | Sample strobe |
| sample_i | input | SAMPLE_W (12) | Signed frequency sample relative to the IF |
| dev_mant_i | input | 4 | Expected-deviation mantissa |
| dev_exp_i | input | 2 | Expected-deviation exponent |
| settle_i | input | 2 | Settling code: 00 off, 01 short, 10 medium, 11 long |
| bit_o | output | 1 | Sliced bit |
| thr_o | output | SAMPLE_W (12) | Threshold in force (signed) |
| thr_valid_o | output | 1 | Learned threshold is in use |
| freq_off_o | output | SAMPLE_W (12) | Learned level, reported as a frequency-offset estimate (signed) |

## Verification
The first pattern is a two-tone preamble with a positive offset. It shows the slicer moving from a zero-referenced decision to the learned level on the third step. Later in the same pattern, a deeper low tone pulls the threshold down, and an equality sample shows that the comparison is strict. The deviation gate is tested with steps exactly at, and one LSB beyond, two different mantissa and exponent settings. Unevenly varying tone levels under the medium and long settings show block averaging with floor rounding on negative values, and show that validity is held back until the block completes. A run with adaptation off, and restarts with and without a colliding sample, show that nothing is learned from ignored input.

// File: rtl/fsk_slicer_pkg.sv
package fsk_slicer_pkg;
  typedef enum logic [1:0] {
    SETTLE_OFF  = 2'b00,
    SETTLE_FAST = 2'b01,
    SETTLE_MID  = 2'b10,
    SETTLE_SLOW = 2'b11
  } settle_e;
endpackage

// File: rtl/fsk_dev_scale.sv
module fsk_dev_scale #(
  parameter int MANT_W    = 4,
  parameter int EXP_W     = 2,
  parameter int DEV_SHIFT = 2,
  parameter int DEV_W     = 13
) (
  input  logic [MANT_W-1:0] mant_i,
  input  logic [EXP_W-1:0]  exp_i,
  output logic [DEV_W-1:0]  dev_o
);
  always_comb dev_o = DEV_W'(mant_i) << (int'(exp_i) + DEV_SHIFT);
endmodule

// File: rtl/fsk_extreme_track.sv
module fsk_extreme_track #(
  parameter int SAMPLE_W = 12,
  parameter int DEV_W    = 13
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       restart_i,
  input  logic                       valid_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic [DEV_W-1:0]           dev_i,
  output logic                       trans_o,
  output logic signed [SAMPLE_W-1:0] est_o,
  output logic signed [SAMPLE_W-1:0] lo_o,
  output logic signed [SAMPLE_W-1:0] hi_o,
  output logic                       seen_o
);
  localparam int DIFF_W = SAMPLE_W + 2;

  logic                       seen_q;
  logic signed [SAMPLE_W-1:0] ref_q, lo_q, hi_q, lo_n, hi_n;
  logic signed [DIFF_W-1:0]   diff, dev_s;
  logic signed [SAMPLE_W:0]   mid_sum;
  logic                       take;

  always_comb begin
    take    = valid_i && !restart_i;
    diff    = DIFF_W'(sample_i) - DIFF_W'(ref_q);
    dev_s   = $signed(DIFF_W'(dev_i));
    trans_o = take && seen_q && ((diff > dev_s) || (-diff > dev_s));
    lo_n    = (!seen_q || sample_i < lo_q) ? sample_i : lo_q;
    hi_n    = (!seen_q || sample_i > hi_q) ? sample_i : hi_q;
    mid_sum = (SAMPLE_W+1)'(lo_n) + (SAMPLE_W+1)'(hi_n);
    est_o   = SAMPLE_W'(mid_sum >>> 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      ref_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else if (restart_i) begin
      seen_q <= 1'b0;
      ref_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else if (valid_i) begin
      seen_q <= 1'b1;
      lo_q   <= lo_n;
      hi_q   <= hi_n;
      if (!seen_q || trans_o) ref_q <= sample_i;
    end
  end

  assign lo_o   = lo_q;
  assign hi_o   = hi_q;
  assign seen_o = seen_q;

  assert_lo_le_hi_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (lo_q <= hi_q));

  assert_step_new_ref_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trans_o |=> (ref_q == $past(sample_i)));
endmodule

// File: rtl/fsk_thr_avg.sv
module fsk_thr_avg
  import fsk_slicer_pkg::*;
#(
  parameter int SAMPLE_W  = 12,
  parameter int FAST_MIN  = 3,
  parameter int MID_LOG2  = 3,
  parameter int SLOW_LOG2 = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       restart_i,
  input  logic                       trans_i,
  input  logic signed [SAMPLE_W-1:0] est_i,
  input  settle_e                    settle_i,
  output logic signed [SAMPLE_W-1:0] avg_o,
  output logic                       valid_o
);
  localparam int MAX_LOG2 = (MID_LOG2 > SLOW_LOG2) ? MID_LOG2 : SLOW_LOG2;
  localparam int BLK_W    = (MAX_LOG2 > 0) ? MAX_LOG2 : 1;
  localparam int CNT_W    = MAX_LOG2 + 3;
  localparam int SUM_W    = SAMPLE_W + MAX_LOG2 + 1;

  logic [CNT_W-1:0]        cnt_q, cnt_n;
  logic [BLK_W-1:0]        blk_q;
  logic signed [SUM_W-1:0] sum_q, sum_n;
  logic signed [SAMPLE_W-1:0] avg_q;
  logic                    valid_q, blk_end, active;
  int                      blk_log2, need;

  always_comb begin
    case (settle_i)
      SETTLE_MID:  begin blk_log2 = MID_LOG2;  need = 1 << MID_LOG2;  end
      SETTLE_SLOW: begin blk_log2 = SLOW_LOG2; need = 1 << SLOW_LOG2; end
      default:     begin blk_log2 = 0;         need = FAST_MIN;       end
    endcase
    active  = trans_i && (settle_i != SETTLE_OFF);
    blk_end = (int'(blk_q) == ((1 << blk_log2) - 1));
    sum_n   = sum_q + SUM_W'(est_i);
    cnt_n   = (&cnt_q) ? cnt_q : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      blk_q   <= '0;
      sum_q   <= '0;
      avg_q   <= '0;
      valid_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q   <= '0;
      blk_q   <= '0;
      sum_q   <= '0;
      avg_q   <= '0;
      valid_q <= 1'b0;
    end else if (active) begin
      cnt_q <= cnt_n;
      if (blk_end) begin
        avg_q <= SAMPLE_W'(sum_n >>> blk_log2);
        sum_q <= '0;
        blk_q <= '0;
      end else begin
        sum_q <= sum_n;
        blk_q <= blk_q + 1'b1;
      end
      if (int'(cnt_n) >= need) valid_q <= 1'b1;
    end
  end

  assign avg_o   = avg_q;
  assign valid_o = valid_q;

  assert_avg_only_on_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trans_i && !restart_i) |=> $stable(avg_o));

  assert_valid_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !restart_i) |=> valid_o);
endmodule

// File: rtl/fsk_adaptive_slicer.sv
module fsk_adaptive_slicer
  import fsk_slicer_pkg::*;
#(
  parameter int SAMPLE_W  = 12,
  parameter int MANT_W    = 4,
  parameter int EXP_W     = 2,
  parameter int DEV_SHIFT = 2,
  parameter int FAST_MIN  = 3,
  parameter int MID_LOG2  = 3,
  parameter int SLOW_LOG2 = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       restart_i,
  input  logic                       valid_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic [MANT_W-1:0]          dev_mant_i,
  input  logic [EXP_W-1:0]           dev_exp_i,
  input  logic [1:0]                 settle_i,
  output logic                       bit_o,
  output logic signed [SAMPLE_W-1:0] thr_o,
  output logic                       thr_valid_o,
  output logic signed [SAMPLE_W-1:0] freq_off_o
);
  localparam int DEV_W = SAMPLE_W + 1;

  settle_e                    settle;
  logic [DEV_W-1:0]           dev;
  logic                       trans, avg_valid, seen, bit_q;
  logic signed [SAMPLE_W-1:0] est, lo, hi, avg, thr_used;

  assign settle = settle_e'(settle_i);

  fsk_dev_scale #(
    .MANT_W(MANT_W), .EXP_W(EXP_W), .DEV_SHIFT(DEV_SHIFT), .DEV_W(DEV_W)
  ) u_dev (
    .mant_i(dev_mant_i), .exp_i(dev_exp_i), .dev_o(dev)
  );

  fsk_extreme_track #(.SAMPLE_W(SAMPLE_W), .DEV_W(DEV_W)) u_track (
    .clk_i, .rst_ni, .restart_i, .valid_i, .sample_i,
    .dev_i(dev), .trans_o(trans), .est_o(est), .lo_o(lo), .hi_o(hi), .seen_o(seen)
  );

  fsk_thr_avg #(
    .SAMPLE_W(SAMPLE_W), .FAST_MIN(FAST_MIN), .MID_LOG2(MID_LOG2), .SLOW_LOG2(SLOW_LOG2)
  ) u_avg (
    .clk_i, .rst_ni, .restart_i, .trans_i(trans), .est_i(est),
    .settle_i(settle), .avg_o(avg), .valid_o(avg_valid)
  );

  always_comb thr_used = (avg_valid && settle != SETTLE_OFF) ? avg : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     bit_q <= 1'b0;
    else if (valid_i && !restart_i)  bit_q <= (sample_i > thr_used);
  end

  assign bit_o       = bit_q;
  assign thr_o       = thr_used;
  assign thr_valid_o = avg_valid && (settle != SETTLE_OFF);
  assign freq_off_o  = avg;

  assert_bit_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i || restart_i) |=> $stable(bit_o));

  assert_bit_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !restart_i && sample_i > thr_o) |=> bit_o);

  assert_off_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (settle_i == 2'b00) |-> (thr_o == '0 && !thr_valid_o));

  assert_restart_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (!thr_valid_o && freq_off_o == '0));

  assert_thr_in_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_valid_o |-> (seen && thr_o >= lo && thr_o <= hi));
endmodule

// File: tb/sim_fsk_adaptive_slicer.sv
module sim_fsk_adaptive_slicer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic restart = 1'b0, valid = 1'b0;
  logic signed [11:0] sample = '0;
  logic [3:0] mant = 4'd4;
  logic [1:0] expo = 2'd0, settle = 2'b01;
  logic bit_o, thr_valid;
  logic signed [11:0] thr, foff;

  int n_checks = 0, n_fail = 0;

  always #5 clk = ~clk;

  fsk_adaptive_slicer u0 (
    .clk_i(clk), .rst_ni(rst_n), .restart_i(restart), .valid_i(valid),
    .sample_i(sample), .dev_mant_i(mant), .dev_exp_i(expo), .settle_i(settle),
    .bit_o(bit_o), .thr_o(thr), .thr_valid_o(thr_valid), .freq_off_o(foff)
  );

  // {sample, bit, valid, thr}, settle 01, deviation 16
  localparam int VEC [14][4] = '{
    '{140, 1, 0, 0}, '{-60, 0, 0, 0}, '{150, 1, 0, 0}, '{-50, 0, 1, 45},
    '{30, 0, 1, 45}, '{50, 1, 1, 45}, '{66, 1, 1, 45}, '{34, 0, 1, 45},
    '{45, 0, 1, 45}, '{46, 1, 1, 45}, '{-100, 0, 1, 25}, '{26, 1, 1, 25},
    '{-101, 0, 1, 24}, '{24, 0, 1, 24}
  };

  // reference state
  int m_seen, m_ref, m_lo, m_hi, m_cnt, m_blk, m_sum, m_avg, m_valid, m_bit;

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic model_clear();
    m_seen = 0; m_ref = 0; m_lo = 0; m_hi = 0; m_cnt = 0;
    m_blk = 0; m_sum = 0; m_avg = 0; m_valid = 0;
  endtask

  task automatic model_step(input int s);
    int thr_m, dev, bsz, lg, need, est;
    dev = int'(mant) << (int'(expo) + 2);
    thr_m = (settle != 2'b00 && m_valid != 0) ? m_avg : 0;
    m_bit = (s > thr_m) ? 1 : 0;
    if (m_seen == 0) begin
      m_seen = 1; m_ref = s; m_lo = s; m_hi = s;
    end else begin
      if (s < m_lo) m_lo = s;
      if (s > m_hi) m_hi = s;
      if ((s - m_ref > dev) || (m_ref - s > dev)) begin
        m_ref = s;
        est = (m_lo + m_hi) >>> 1;
        if (settle != 2'b00) begin
          lg   = (settle == 2'b10) ? 3 : (settle == 2'b11) ? 4 : 0;
          bsz  = 1 << lg;
          need = (settle == 2'b01) ? 3 : bsz;
          m_sum += est; m_blk++; m_cnt++;
          if (m_blk == bsz) begin m_avg = m_sum >>> lg; m_sum = 0; m_blk = 0; end
          if (m_cnt >= need) m_valid = 1;
        end
      end
    end
  endtask

  task automatic send(input int s);
    @(negedge clk);
    sample = 12'(s); valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic do_restart();
    @(negedge clk);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    model_clear();
  endtask

  task automatic send_model(input int s, input string req);
    int exp_thr;
    model_step(s);
    send(s);
    exp_thr = (settle != 2'b00 && m_valid != 0) ? m_avg : 0;
    check(bit_o == m_bit[0], {req, " bit"}, int'(bit_o), m_bit);
    check(int'(thr_valid) == ((settle != 2'b00) ? m_valid : 0), {req, " valid"}, int'(thr_valid), m_valid);
    check(int'(thr) == exp_thr, {req, " thr"}, int'(thr), exp_thr);
    check(int'(foff) == m_avg, {req, " freq_off"}, int'(foff), m_avg);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    // R12: reset state
    repeat (3) @(negedge clk);
    check(bit_o == 1'b0 && thr == '0 && !thr_valid && foff == '0, "R12 outputs in reset",
          int'(thr_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(bit_o == 1'b0 && thr == '0 && foff == '0, "R12 after release", int'(foff), 0);

    // R1, R5, R9: vector table, settle 01, deviation 16
    mant = 4'd4; expo = 2'd0; settle = 2'b01;
    do_restart();
    for (int k = 0; k < 14; k++) begin
      send(VEC[k][0]);
      check(int'(bit_o) == VEC[k][1], $sformatf("R1 bit vec %0d", k), int'(bit_o), VEC[k][1]);
      check(int'(thr_valid) == VEC[k][2], $sformatf("R5 valid vec %0d", k), int'(thr_valid), VEC[k][2]);
      check(int'(thr) == VEC[k][3], $sformatf("R9 thr vec %0d", k), int'(thr), VEC[k][3]);
      if (k == 1) check(int'(foff) == 40, "R10 freq_off before valid", int'(foff), 40);
      if (k == 13) check(int'(foff) == 24, "R4 floor midpoint", int'(foff), 24);
    end

    // R2, R3: deviation 5<<3 = 40
    mant = 4'd5; expo = 2'd1; settle = 2'b01;
    do_restart();
    send(0);
    send(40);
    check(foff == '0, "R3 step equal to deviation ignored", int'(foff), 0);
    check(bit_o == 1'b1, "R1 bit vs zero before valid", int'(bit_o), 1);
    send(-1);
    send(41);
    check(int'(foff) == 20, "R2 step beyond deviation 40", int'(foff), 20);
    // deviation 1<<5 = 32
    mant = 4'd1; expo = 2'd3;
    do_restart();
    send(0);
    send(32);
    check(foff == '0, "R2 step of 32 ignored", int'(foff), 0);
    send(33);
    check(int'(foff) == 16, "R2 step of 33 counted", int'(foff), 16);

    // R6: settle 10, blocks of 8, negative offset
    mant = 4'd5; expo = 2'd1; settle = 2'b10;
    do_restart();
    send_model(50, "R6");
    for (int i = 0; i < 22; i++)
      send_model((i % 2 == 0) ? (-110 - (i % 5)) : (50 + (i % 3)), "R6");

    // R7: settle 11, blocks of 16, positive offset
    settle = 2'b11;
    do_restart();
    send_model(150, "R7");
    for (int i = 0; i < 36; i++)
      send_model((i % 2 == 0) ? (-10 - (i % 7)) : (150 + (i % 4)), "R7");

    // R8: adaptation off
    settle = 2'b00;
    do_restart();
    for (int i = 0; i < 10; i++) send_model((i % 2 == 0) ? 140 : -60, "R8");
    send_model(30, "R8");
    check(bit_o == 1'b1 && !thr_valid && thr == '0, "R8 off slices at zero", int'(bit_o), 1);

    // R11: restart clears learned state and drops a colliding sample
    settle = 2'b01; mant = 4'd4; expo = 2'd0;
    do_restart();
    send(140); send(-60); send(150); send(-50); send(160);
    check(thr_valid == 1'b1 && bit_o == 1'b1, "R11 valid before restart", int'(thr_valid), 1);
    do_restart();
    check(!thr_valid && thr == '0 && foff == '0, "R11 restart clears", int'(foff), 0);
    @(negedge clk);
    restart = 1'b1; valid = 1'b1; sample = -12'sd500;
    @(negedge clk);
    restart = 1'b0; valid = 1'b0;
    check(bit_o == 1'b1, "R11 bit held over colliding sample", int'(bit_o), 1);
    send(140);
    send(-60);
    check(int'(foff) == 40, "R11 colliding sample not tracked", int'(foff), 40);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule